// File: doc/BRIEF.md
# DDR2 Late Power-Up Sequencer

This block drives the closing stretch of DDR2 device bring-up on its own, with no software involvement. Once the earlier supply and clock settling is complete, a single start pulse launches a fixed series of eight commands. The series runs in this order: an extended mode write (bank 1) that turns the DLL on, a lock wait, a mode write that resets the DLL, a precharge of every bank, and two refreshes. After those come a mode write with the final CAS latency and burst length and DLL reset cleared, then two extended mode writes that enter and leave the default drive-calibration setting.

The command bundle is chip select, row strobe, column strobe, write enable, bank address and row address. A command is present for exactly one cycle, and the bundle is held deselected at all other times. The spacing between commands is set by three parameters: a long lock wait after the DLL is turned on, a refresh-to-refresh interval between the two refreshes, and a short mode-register interval everywhere else. A done flag rises once the whole series has finished and stays high until the next start is accepted. A start that arrives while the series is running is dropped.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and until a start is accepted, all four command pins are high (deselect) and done_o is low.
- R2: After an accepted start, exactly eight commands are issued in this order. Each is encoded as {cs_n,ras_n,cas_n,we_n}, with mode write = 0000, precharge = 0010 and refresh = 0001. The order is: mode write with BA=01 (DLL on), mode write with BA=00 (DLL reset), precharge with A10=1 and BA=00, refresh, refresh, mode write with BA=00 (final), mode write with BA=01 (calibration default), mode write with BA=01 (calibration exit).
- R3: The command after the DLL-on write issues exactly LOCK_CYC cycles after it (default 200).
- R4: Both BA=00 mode writes carry cas_lat_i on A[6:4] and burst_len_i on A[2:0] (010 = 4, 011 = 8). A8 is 1 in the first of them and 0 in the final one. All other address bits are 0.
- R5: The BA=01 writes carry A[9:7] = 000 and A0 = 0 for DLL on, A[9:7] = 111 for calibration default, and A[9:7] = 000 for calibration exit. All other address bits are 0.
- R6: The second refresh issues exactly TRFC_CYC cycles after the first (default 26).
- R7: Every other pair of consecutive commands is separated by exactly TMRD_CYC cycles (default 2).
- R8: done_o rises exactly TMRD_CYC cycles after the final write. It stays high, with no further commands, until a new start is accepted.
- R9: A start pulse while the sequence is running has no effect: no extra commands are issued and the timing is unchanged.
- R10: A start while done_o is high is accepted. done_o falls and the first command appears in the cycle after the start is sampled.
- R11: Each command occupies exactly one clock cycle and is followed by deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled on the rising edge |
| cas_lat_i | input | 3 | CAS latency code for the mode writes |
| burst_len_i | input | 3 | Burst length code for the mode writes |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Row address / mode payload |
| done_o | output | 1 | Sequence complete |

## Verification
Two events can land in the same cycle: a start request and the issue of a command, including the last one, which sets when done rises. The bench raises start during the cycle in which the final calibration-exit write is on the pins, and again early in the lock wait. It then checks that the command count stays at eight, that done rises exactly TMRD_CYC cycles after the final write, and that nothing further is issued. A start given after done is judged by done falling, with the DLL-on write appearing in the very next cycle.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {
    FSM_IDLE  = 2'd0,
    FSM_ISSUE = 2'd1,
    FSM_WAIT  = 2'd2,
    FSM_DONE  = 2'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    STEP_DLL_ON      = 3'd0,
    STEP_DLL_RESET   = 3'd1,
    STEP_PRECHARGE   = 3'd2,
    STEP_REFRESH_A   = 3'd3,
    STEP_REFRESH_B   = 3'd4,
    STEP_MODE_FINAL  = 3'd5,
    STEP_OCD_DEFAULT = 3'd6,
    STEP_OCD_EXIT    = 3'd7
  } seq_step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam cmd_pins_t PINS_DESEL = 4'b1111;
  localparam cmd_pins_t PINS_MODE  = 4'b0000;
  localparam cmd_pins_t PINS_PRE   = 4'b0010;
  localparam cmd_pins_t PINS_REF   = 4'b0001;

  localparam logic [1:0] BANK_BASE = 2'b00;
  localparam logic [1:0] BANK_EXT1 = 2'b01;

  // payload bit positions decoded by the memory device
  localparam int MR_BL_LSB      = 0;
  localparam int MR_CL_LSB      = 4;
  localparam int MR_DLL_RST_BIT = 8;
  localparam int EMR_OCD_LSB    = 7;
  localparam int PRE_ALL_BIT    = 10;

endpackage

// File: rtl/ddr2_init_rst_sync.sv
module ddr2_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ddr2_init_gap_timer.sv
module ddr2_init_gap_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          run_i,
  output logic          expire_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = load_val_i;
      cnt_en = 1'b1;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire_o = run_i && (cnt_q == {{(CW-1){1'b0}}, 1'b1});

endmodule

// File: rtl/ddr2_init_cmd_enc.sv
module ddr2_init_cmd_enc
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              issue_i,
  input  seq_step_e         step_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  output cmd_pins_t         pins_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] mode_word;

  always_comb begin
    mode_word = '0;
    mode_word[MR_CL_LSB +: 3] = cas_lat_i;
    mode_word[MR_BL_LSB +: 3] = burst_len_i;
  end

  always_comb begin
    pins_o = PINS_DESEL;
    ba_o   = BANK_BASE;
    addr_o = '0;
    if (issue_i) begin
      unique case (step_i)
        STEP_DLL_ON: begin
          pins_o = PINS_MODE;
          ba_o   = BANK_EXT1;
        end
        STEP_DLL_RESET: begin
          pins_o = PINS_MODE;
          addr_o = mode_word;
          addr_o[MR_DLL_RST_BIT] = 1'b1;
        end
        STEP_PRECHARGE: begin
          pins_o = PINS_PRE;
          addr_o[PRE_ALL_BIT] = 1'b1;
        end
        STEP_REFRESH_A,
        STEP_REFRESH_B: begin
          pins_o = PINS_REF;
        end
        STEP_MODE_FINAL: begin
          pins_o = PINS_MODE;
          addr_o = mode_word;
        end
        STEP_OCD_DEFAULT: begin
          pins_o = PINS_MODE;
          ba_o   = BANK_EXT1;
          addr_o[EMR_OCD_LSB +: 3] = 3'b111;
        end
        STEP_OCD_EXIT: begin
          pins_o = PINS_MODE;
          ba_o   = BANK_EXT1;
        end
        default: begin
          pins_o = PINS_DESEL;
        end
      endcase
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int LOCK_CYC = 200,
  parameter int TRFC_CYC = 26,
  parameter int TMRD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int MAX_A   = (LOCK_CYC > TRFC_CYC) ? LOCK_CYC : TRFC_CYC;
  localparam int MAX_GAP = (MAX_A > TMRD_CYC) ? MAX_A : TMRD_CYC;
  localparam int CW      = $clog2(MAX_GAP + 1);
  localparam logic [CW-1:0] LOCK_LD = CW'(LOCK_CYC - 1);
  localparam logic [CW-1:0] TRFC_LD = CW'(TRFC_CYC - 1);
  localparam logic [CW-1:0] TMRD_LD = CW'(TMRD_CYC - 1);

  logic       core_rst_n;
  seq_state_e state_q, state_d;
  seq_step_e  step_q, step_d;
  logic       fsm_en;
  logic       gap_load;
  logic [CW-1:0] gap_val;
  logic       gap_expire;
  cmd_pins_t  pins;

  ddr2_init_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  always_comb begin
    unique case (step_q)
      STEP_DLL_ON:    gap_val = LOCK_LD;
      STEP_REFRESH_A: gap_val = TRFC_LD;
      default:        gap_val = TMRD_LD;
    endcase
  end

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    gap_load = 1'b0;
    unique case (state_q)
      FSM_IDLE, FSM_DONE: begin
        if (start_i) begin
          state_d = FSM_ISSUE;
          step_d  = STEP_DLL_ON;
        end
      end
      FSM_ISSUE: begin
        state_d  = FSM_WAIT;
        gap_load = 1'b1;
      end
      FSM_WAIT: begin
        if (gap_expire) begin
          if (step_q == STEP_OCD_EXIT) begin
            state_d = FSM_DONE;
          end else begin
            state_d = FSM_ISSUE;
            step_d  = seq_step_e'(step_q + 3'd1);
          end
        end
      end
      default: state_d = FSM_IDLE;
    endcase
  end

  assign fsm_en = (state_d != state_q);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= FSM_IDLE;
      step_q  <= STEP_DLL_ON;
    end else if (fsm_en) begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  ddr2_init_gap_timer #(.CW(CW)) u_gap (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .load_i     (gap_load),
    .load_val_i (gap_val),
    .run_i      (state_q == FSM_WAIT),
    .expire_o   (gap_expire)
  );

  ddr2_init_cmd_enc #(.ADDR_W(ADDR_W)) u_enc (
    .issue_i     (state_q == FSM_ISSUE),
    .step_i      (step_q),
    .cas_lat_i   (cas_lat_i),
    .burst_len_i (burst_len_i),
    .pins_o      (pins),
    .ba_o        (ba_o),
    .addr_o      (addr_o)
  );

  assign cs_n_o  = pins.cs_n;
  assign ras_n_o = pins.ras_n;
  assign cas_n_o = pins.cas_n;
  assign we_n_o  = pins.we_n;
  assign done_o  = (state_q == FSM_DONE);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int LOCK_CYC = 200,
  parameter int TRFC_CYC = 26,
  parameter int TMRD_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cas_lat_i,
  input logic [2:0]        burst_len_i,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  localparam int GW = $clog2(LOCK_CYC + TRFC_CYC + TMRD_CYC + 1) + 1;
  localparam logic [GW-1:0] GMAX = '1;

  logic [GW-1:0] since_q;
  logic          prev_ref_q;
  logic          is_cmd, is_mode, is_pre, is_ref;

  assign is_cmd  = !cs_n_o;
  assign is_mode = is_cmd && !ras_n_o && !cas_n_o && !we_n_o;
  assign is_pre  = is_cmd && !ras_n_o &&  cas_n_o && !we_n_o;
  assign is_ref  = is_cmd && !ras_n_o && !cas_n_o &&  we_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q    <= GMAX;
      prev_ref_q <= 1'b0;
    end else begin
      if (is_cmd) begin
        since_q    <= {{(GW-1){1'b0}}, 1'b1};
        prev_ref_q <= is_ref;
      end else if (since_q != GMAX) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (cs_n_o && !done_o);
    end
  end

  // R2
  legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (is_mode || is_pre || is_ref));

  // R11
  one_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |=> cs_n_o);

  // R7
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_q >= GW'(TMRD_CYC)));

  // R6
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && prev_ref_q) |-> (since_q == GW'(TRFC_CYC)));

  // R3
  lock_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mode && ba_o == 2'b00 && addr_o[8]) |-> (since_q >= GW'(LOCK_CYC)));

  // R4
  mode_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mode && ba_o == 2'b00) |-> (addr_o[6:4] == cas_lat_i && addr_o[2:0] == burst_len_i));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o);

  // R8
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (since_q == GW'(TMRD_CYC)));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .ADDR_W   (ADDR_W),
  .LOCK_CYC (LOCK_CYC),
  .TRFC_CYC (TRFC_CYC),
  .TMRD_CYC (TMRD_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cas_lat_i   (cas_lat_i),
  .burst_len_i (burst_len_i),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .done_o      (done_o)
);

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;

  localparam int CLK_P  = 10;
  localparam int AW     = 13;
  localparam int LOCK   = 200;
  localparam int TRFC   = 26;
  localparam int TMRD   = 2;

  logic clk, rst_n, start;
  logic [2:0] cl, bl;
  logic cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  int total, bad, cyc;

  ddr2_init_seq #(.ADDR_W(AW), .LOCK_CYC(LOCK), .TRFC_CYC(TRFC), .TMRD_CYC(TMRD)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cas_lat_i(cl), .burst_len_i(bl),
    .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // command / done log, sampled mid-cycle
  int            ev_cyc [64];
  logic [3:0]    ev_code[64];
  logic [1:0]    ev_ba  [64];
  logic [AW-1:0] ev_addr[64];
  int            n_ev;
  int            d_cyc[8];
  int            n_done;
  logic          done_prev;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && n_ev < 64) begin
        ev_cyc[n_ev]  = cyc;
        ev_code[n_ev] = {cs_n, ras_n, cas_n, we_n};
        ev_ba[n_ev]   = ba;
        ev_addr[n_ev] = addr;
        n_ev = n_ev + 1;
      end
      if (done && !done_prev && n_done < 8) begin
        d_cyc[n_done] = cyc;
        n_done = n_done + 1;
      end
      done_prev = done;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int i);
    if (i == 2) return 4'b0010;
    if (i == 3 || i == 4) return 4'b0001;
    return 4'b0000;
  endfunction

  function automatic logic [1:0] exp_ba(input int i);
    return (i == 0 || i == 6 || i == 7) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int i, input logic [2:0] c, input logic [2:0] b);
    logic [AW-1:0] a;
    a = '0;
    case (i)
      1: begin a[8] = 1'b1; a[6:4] = c; a[2:0] = b; end
      2: a[10] = 1'b1;
      5: begin a[6:4] = c; a[2:0] = b; end
      6: a[9:7] = 3'b111;
      default: a = '0;
    endcase
    return a;
  endfunction

  function automatic int exp_gap(input int i);
    if (i == 0) return LOCK;
    if (i == 3) return TRFC;
    return TMRD;
  endfunction

  task automatic pulse_start(input logic check_accept);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (check_accept) begin
      // R10: done falls, first command already on the pins
      chk(!done, "R10 done low after restart", done, 0);
      chk(!cs_n, "R10 first command next cycle", cs_n, 0);
    end
  endtask

  task automatic wait_done(input int dbase);
    for (int k = 0; k < 2000 && n_done == dbase; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_run(input int base, input int dbase, input logic [2:0] c, input logic [2:0] b);
    chk(n_ev - base >= 8, "R2 command count", n_ev - base, 8);
    for (int i = 0; i < 8; i++) begin
      chk(ev_code[base+i] == exp_code(i), "R2 command pins", ev_code[base+i], exp_code(i));
      chk(ev_ba[base+i] == exp_ba(i), "R2 bank", ev_ba[base+i], exp_ba(i));
      chk(ev_addr[base+i] == exp_addr(i, c, b),
          (i == 1 || i == 5) ? "R4 mode payload" : "R5 payload", ev_addr[base+i], exp_addr(i, c, b));
    end
    for (int i = 0; i < 7; i++) begin
      chk(ev_cyc[base+i+1] - ev_cyc[base+i] == exp_gap(i),
          (i == 0) ? "R3 lock gap" : (i == 3) ? "R6 refresh gap" : "R7 mode gap",
          ev_cyc[base+i+1] - ev_cyc[base+i], exp_gap(i));
    end
    chk(n_done > dbase && d_cyc[dbase] - ev_cyc[base+7] == TMRD, "R8 done timing",
        d_cyc[dbase] - ev_cyc[base+7], TMRD);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n && ras_n && cas_n && we_n, "R1 deselect in reset", {cs_n, ras_n, cas_n, we_n}, 15);
    chk(!done, "R1 done low in reset", done, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_n && !done && n_ev == 0, "R1 idle without start", n_ev, 0);
  endtask

  task automatic t_basic();
    int base, dbase;
    cl = 3'd3; bl = 3'b010;
    base = n_ev; dbase = n_done;
    pulse_start(1'b0);
    // R11: a single command cycle follows the start
    chk(!cs_n, "R11 command after start", cs_n, 0);
    @(negedge clk);
    chk(cs_n, "R11 one-cycle command", cs_n, 1);
    wait_done(dbase);
    check_run(base, dbase, cl, bl);
  endtask

  task automatic t_busy_start();
    int base, dbase, seen;
    cl = 3'd4; bl = 3'b011;
    base = n_ev; dbase = n_done; seen = 0;
    pulse_start(1'b0);
    seen = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 1000 && seen < 8; k++) begin
      @(negedge clk);
      if (!cs_n) seen++;
    end
    // start raised while the final write is on the pins
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(dbase);
    check_run(base, dbase, cl, bl);
    repeat (300) @(negedge clk);
    chk(n_ev - base == 8, "R9 no extra commands", n_ev - base, 8);
    chk(done, "R8 done held", done, 1);
  endtask

  task automatic t_restart();
    int base, dbase;
    cl = 3'd5; bl = 3'b010;
    base = n_ev; dbase = n_done;
    pulse_start(1'b1);
    wait_done(dbase);
    check_run(base, dbase, cl, bl);
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; n_ev = 0; n_done = 0; done_prev = 1'b0;
    rst_n = 1'b0; start = 1'b0; cl = 3'd3; bl = 3'b010;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_busy_start();
    t_restart();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule